// File: doc/BRIEF.md
# Lane Configuration Source Selector

This block decides where each lane of a multi-lane repeater takes its settings from: equalization, de-emphasis, output amplitude, termination disable, the device mode code and the signal-detect threshold. A single mode input picks between strap control and register control. Under strap control the settings are grouped by side. Lanes in the lower half belong to side A and lanes in the upper half to side B. Each side has two equalization straps and one de-emphasis strap. Every strap arrives as an already resolved 2-bit level code.

Under register control every lane has its own register fields. The four equalization straps no longer set equalization. Instead they supply a 4-bit bus address. The block contains the register bank, a simple write port, a per-field pin override flag for amplitude, termination and threshold, and the rules that return the bank to its defaults.

Switching between the two sources takes effect in the same cycle as the mode input. The register bank is cleared while strap control is active. The external reset has no effect on the bank while register control is active.

Top module: `cfgsel_top`

## Requirements
- R1: With `reg_mode_i`=0, the equalization code of a lane is idx*17. Here idx = {eq1, eq0}, the two 2-bit level codes of that lane's side. Side A covers lanes 0..N/2-1 and side B covers lanes N/2..N-1.
- R2: With `reg_mode_i`=0, the de-emphasis code of a lane is twice the de-emphasis level of its side. Each side is set independently.
- R3: With `reg_mode_i`=0, the amplitude code is `pin_vod_i`+2+boost. The boost is 0, 1, 1 or 2 for side de-emphasis level 0, 1, 2 or 3.
- R4: In the cycle `reg_mode_i` is 1, lane equalization, lane de-emphasis and `mode_o` come from the registers, with no added latency. The de-emphasis straps and equalization straps then have no effect on them.
- R5: `bus_addr_o` is {eq_b1[1], eq_b0[1], eq_a1[1], eq_a0[1]} while `reg_mode_i`=1, and 0 while `reg_mode_i`=0.
- R6: With `reg_mode_i`=1, the following values follow their straps until the matching override flag is set: a lane's amplitude (`pin_vod_i`+2, no boost), its termination disable (`pin_term_i`), and `sdth_o` (`pin_sdth_i`). Once the flag is set, the register value is used and the strap is ignored.
- R7: After `por_n` low, and after any clock edge with `reg_mode_i`=0, all registers hold their defaults. The defaults are: eq 0, dem 0, vod 2, term 0, mode 0, threshold 0, all override flags 0.
- R8: Asserting `ext_rst_i` while `reg_mode_i`=1 leaves every register unchanged.
- R9: A write presented while `reg_mode_i`=0 is discarded. This includes the cycle in which the mode input falls.
- R10: The register map is laid out as follows.
  - Address 0 holds the global fields: mode in bits 1:0, threshold in bits 3:2, threshold override in bit 4.
  - Lane L owns addresses 16+4L+s.
  - s=0 holds eq in bits 7:0.
  - s=1 holds dem in bits 2:0 and vod in bits 6:4.
  - s=2 holds term in bit 0, vod override in bit 4 and term override in bit 5.
  - s=3 and every other address are ignored.
- R11: In register mode, a write to one lane changes no other lane's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_i | input | 1 | External reset request, honoured only in strap mode |
| reg_mode_i | input | 1 | 0 = strap control, 1 = register control |
| pin_eq_a0_i | input | 2 | Side A equalization strap 0 level |
| pin_eq_a1_i | input | 2 | Side A equalization strap 1 level |
| pin_eq_b0_i | input | 2 | Side B equalization strap 0 level |
| pin_eq_b1_i | input | 2 | Side B equalization strap 1 level |
| pin_dem_a_i | input | 2 | Side A de-emphasis strap level |
| pin_dem_b_i | input | 2 | Side B de-emphasis strap level |
| pin_mode_i | input | 2 | Mode strap level |
| pin_vod_i | input | 2 | Amplitude strap level |
| pin_sdth_i | input | 2 | Signal-detect threshold strap level |
| pin_term_i | input | 1 | Termination disable strap |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | 8 | Register write data |
| lane_eq_o | output | 32 | Per-lane equalization codes, lane L at bits 8L+7:8L |
| lane_dem_o | output | 12 | Per-lane de-emphasis codes, 3 bits per lane |
| lane_vod_o | output | 12 | Per-lane amplitude codes, 3 bits per lane |
| lane_term_dis_o | output | 4 | Per-lane termination disable |
| mode_o | output | 2 | Active mode code |
| sdth_o | output | 2 | Active signal-detect threshold |
| bus_addr_o | output | 4 | Bus address bits taken from the equalization straps |

## Verification
The bench sweeps all sixteen strap equalization settings per side, with the two sides always set differently. A design that merged the sides, or swapped the strap order, would show the wrong code on half of the lanes. It also runs every de-emphasis and amplitude strap pair, so a wrong boost entry or a missing boost shows up as an amplitude off by one or two.

Mode transitions are checked in the cycle where they happen. A register-sourced value that arrives a cycle late would still show the strap code at the check. A write that lands in the cycle of the falling mode edge would survive into the next register session if write priority beat the clear. An override flag that outlives strap mode would hold a lane's amplitude at a stale register value.

Three further cases are covered. An ext-reset pulse in register mode must leave written values intact. A lane write must not spill into its neighbours. Unmapped sub-addresses must be dropped.

// File: rtl/cfgsel_pkg.sv
package cfgsel_pkg;

    localparam int unsigned LVL_W    = 2;
    localparam int unsigned EQ_W     = 8;
    localparam int unsigned DEM_W    = 3;
    localparam int unsigned VOD_W    = 3;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned BADDR_W  = 4;
    localparam int unsigned VOD_BASE = 2;

    typedef struct packed {
        logic [EQ_W-1:0]  eq;
        logic [DEM_W-1:0] dem;
        logic [VOD_W-1:0] vod;
        logic             term_dis;
        logic             ovr_vod;
        logic             ovr_term;
    } lane_reg_t;

    typedef struct packed {
        logic [LVL_W-1:0] mode;
        logic [LVL_W-1:0] sdth;
        logic             ovr_sdth;
    } glob_reg_t;

    typedef struct packed {
        logic [EQ_W-1:0]  eq;
        logic [DEM_W-1:0] dem;
        logic [VOD_W-1:0] vod;
        logic             term_dis;
    } lane_cfg_t;

    localparam lane_reg_t LANE_DEFAULT = '{
        eq: '0, dem: '0, vod: VOD_W'(VOD_BASE),
        term_dis: 1'b0, ovr_vod: 1'b0, ovr_term: 1'b0
    };

    localparam glob_reg_t GLOB_DEFAULT = '{mode: '0, sdth: '0, ovr_sdth: 1'b0};

    // Strap index to full equalization code: nibble replicated across the byte.
    function automatic logic [EQ_W-1:0] strap_eq_code(input logic [3:0] idx);
        return {idx, idx};
    endfunction

    // Amplitude boost applied in strap mode when de-emphasis is active.
    function automatic logic [VOD_W-1:0] dem_vod_boost(input logic [LVL_W-1:0] lvl);
        logic [VOD_W-1:0] b;
        case (lvl)
            2'd0:    b = 3'd0;
            2'd3:    b = 3'd2;
            default: b = 3'd1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/cfgsel_regbank.sv
module cfgsel_regbank
    import cfgsel_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned LANE_W    = $clog2(NUM_LANES),
    parameter int unsigned ADDR_W    = LANE_W + 3
) (
    input  logic                         clk,
    input  logic                         por_n,
    input  logic                         ext_rst_i,
    input  logic                         reg_mode_i,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            wr_addr_i,
    input  logic [DATA_W-1:0]            wr_data_i,
    output glob_reg_t                    glob_o,
    output lane_reg_t [NUM_LANES-1:0]    lanes_o
);

    typedef struct packed {
        glob_reg_t                 glob;
        lane_reg_t [NUM_LANES-1:0] lanes;
    } bank_t;

    bank_t bank_d, bank_q;

    logic              rst_gate;
    logic              clr;
    logic              lane_space;
    logic [LANE_W-1:0] lane_idx;
    logic [1:0]        sub_sel;

    assign rst_gate   = ext_rst_i & ~reg_mode_i;
    assign clr        = ~reg_mode_i | rst_gate;
    assign lane_space = wr_addr_i[ADDR_W-1];
    assign lane_idx   = wr_addr_i[ADDR_W-2 -: LANE_W];
    assign sub_sel    = wr_addr_i[1:0];

    always_comb begin
        bank_d = bank_q;
        if (clr) begin
            bank_d.glob = GLOB_DEFAULT;
            for (int l = 0; l < NUM_LANES; l++) begin
                bank_d.lanes[l] = LANE_DEFAULT;
            end
        end else if (wr_en_i) begin
            if (wr_addr_i == '0) begin
                bank_d.glob.mode     = wr_data_i[1:0];
                bank_d.glob.sdth     = wr_data_i[3:2];
                bank_d.glob.ovr_sdth = wr_data_i[4];
            end else if (lane_space) begin
                for (int l = 0; l < NUM_LANES; l++) begin
                    if (lane_idx == LANE_W'(l)) begin
                        case (sub_sel)
                            2'd0: bank_d.lanes[l].eq = wr_data_i;
                            2'd1: begin
                                bank_d.lanes[l].dem = wr_data_i[2:0];
                                bank_d.lanes[l].vod = wr_data_i[6:4];
                            end
                            2'd2: begin
                                bank_d.lanes[l].term_dis = wr_data_i[0];
                                bank_d.lanes[l].ovr_vod  = wr_data_i[4];
                                bank_d.lanes[l].ovr_term = wr_data_i[5];
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            bank_q.glob <= GLOB_DEFAULT;
            for (int l = 0; l < NUM_LANES; l++) begin
                bank_q.lanes[l] <= LANE_DEFAULT;
            end
        end else begin
            bank_q <= bank_d;
        end
    end

    assign glob_o  = bank_q.glob;
    assign lanes_o = bank_q.lanes;

    AST_STRAP_MODE_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        !reg_mode_i |=> (bank_q.glob == GLOB_DEFAULT && bank_q.lanes[0] == LANE_DEFAULT
                          && bank_q.lanes[NUM_LANES-1] == LANE_DEFAULT)); // R7

    AST_STRAP_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!por_n)
        (!reg_mode_i && wr_en_i) |=> (bank_q.lanes[0].eq == '0)); // R9

    AST_EXT_RST_NO_EFFECT: assert property (@(posedge clk) disable iff (!por_n)
        (reg_mode_i && ext_rst_i && !wr_en_i) |=> $stable(bank_q)); // R8

endmodule

// File: rtl/cfgsel_strap_decode.sv
module cfgsel_strap_decode
    import cfgsel_pkg::*;
(
    input  logic                   reg_mode_i,
    input  logic [LVL_W-1:0]       eq_a0_i,
    input  logic [LVL_W-1:0]       eq_a1_i,
    input  logic [LVL_W-1:0]       eq_b0_i,
    input  logic [LVL_W-1:0]       eq_b1_i,
    input  logic [LVL_W-1:0]       dem_a_i,
    input  logic [LVL_W-1:0]       dem_b_i,
    input  logic [LVL_W-1:0]       vod_i,
    output logic [1:0][EQ_W-1:0]   side_eq_o,
    output logic [1:0][DEM_W-1:0]  side_dem_o,
    output logic [1:0][VOD_W-1:0]  side_vod_o,
    output logic [VOD_W-1:0]       vod_base_o,
    output logic [BADDR_W-1:0]     bus_addr_o
);

    logic [1:0][LVL_W-1:0] dem_lvl;

    assign dem_lvl[0] = dem_a_i;
    assign dem_lvl[1] = dem_b_i;

    assign vod_base_o = VOD_W'(vod_i) + VOD_W'(VOD_BASE);

    assign side_eq_o[0] = strap_eq_code({eq_a1_i, eq_a0_i});
    assign side_eq_o[1] = strap_eq_code({eq_b1_i, eq_b0_i});

    for (genvar s = 0; s < 2; s++) begin : g_side
        assign side_dem_o[s] = {dem_lvl[s], 1'b0};
        assign side_vod_o[s] = vod_base_o + dem_vod_boost(dem_lvl[s]);
    end

    assign bus_addr_o = reg_mode_i ? {eq_b1_i[1], eq_b0_i[1], eq_a1_i[1], eq_a0_i[1]}
                                   : '0;

endmodule

// File: rtl/cfgsel_lane_mux.sv
module cfgsel_lane_mux
    import cfgsel_pkg::*;
(
    input  logic              reg_mode_i,
    input  lane_reg_t         lane_reg_i,
    input  logic [EQ_W-1:0]   strap_eq_i,
    input  logic [DEM_W-1:0]  strap_dem_i,
    input  logic [VOD_W-1:0]  strap_vod_i,
    input  logic [VOD_W-1:0]  vod_base_i,
    input  logic              pin_term_i,
    output lane_cfg_t         cfg_o
);

    always_comb begin
        if (reg_mode_i) begin
            cfg_o.eq       = lane_reg_i.eq;
            cfg_o.dem      = lane_reg_i.dem;
            cfg_o.vod      = lane_reg_i.ovr_vod  ? lane_reg_i.vod      : vod_base_i;
            cfg_o.term_dis = lane_reg_i.ovr_term ? lane_reg_i.term_dis : pin_term_i;
        end else begin
            cfg_o.eq       = strap_eq_i;
            cfg_o.dem      = strap_dem_i;
            cfg_o.vod      = strap_vod_i;
            cfg_o.term_dis = pin_term_i;
        end
    end

endmodule

// File: rtl/cfgsel_top.sv
module cfgsel_top
    import cfgsel_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned LANE_W    = $clog2(NUM_LANES),
    parameter int unsigned ADDR_W    = LANE_W + 3
) (
    input  logic                        clk,
    input  logic                        por_n,
    input  logic                        ext_rst_i,
    input  logic                        reg_mode_i,
    input  logic [1:0]                  pin_eq_a0_i,
    input  logic [1:0]                  pin_eq_a1_i,
    input  logic [1:0]                  pin_eq_b0_i,
    input  logic [1:0]                  pin_eq_b1_i,
    input  logic [1:0]                  pin_dem_a_i,
    input  logic [1:0]                  pin_dem_b_i,
    input  logic [1:0]                  pin_mode_i,
    input  logic [1:0]                  pin_vod_i,
    input  logic [1:0]                  pin_sdth_i,
    input  logic                        pin_term_i,
    input  logic                        wr_en_i,
    input  logic [ADDR_W-1:0]           wr_addr_i,
    input  logic [7:0]                  wr_data_i,
    output logic [NUM_LANES*8-1:0]      lane_eq_o,
    output logic [NUM_LANES*3-1:0]      lane_dem_o,
    output logic [NUM_LANES*3-1:0]      lane_vod_o,
    output logic [NUM_LANES-1:0]        lane_term_dis_o,
    output logic [1:0]                  mode_o,
    output logic [1:0]                  sdth_o,
    output logic [3:0]                  bus_addr_o
);

    localparam int unsigned HALF = NUM_LANES / 2;

    glob_reg_t                 glob_q;
    lane_reg_t [NUM_LANES-1:0] lanes_q;
    logic [1:0][EQ_W-1:0]      side_eq;
    logic [1:0][DEM_W-1:0]     side_dem;
    logic [1:0][VOD_W-1:0]     side_vod;
    logic [VOD_W-1:0]          vod_base;
    lane_cfg_t [NUM_LANES-1:0] lane_cfg;

    cfgsel_regbank #(
        .NUM_LANES (NUM_LANES),
        .LANE_W    (LANE_W),
        .ADDR_W    (ADDR_W)
    ) regbank_i (
        .clk        (clk),
        .por_n      (por_n),
        .ext_rst_i  (ext_rst_i),
        .reg_mode_i (reg_mode_i),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .glob_o     (glob_q),
        .lanes_o    (lanes_q)
    );

    cfgsel_strap_decode strap_i (
        .reg_mode_i (reg_mode_i),
        .eq_a0_i    (pin_eq_a0_i),
        .eq_a1_i    (pin_eq_a1_i),
        .eq_b0_i    (pin_eq_b0_i),
        .eq_b1_i    (pin_eq_b1_i),
        .dem_a_i    (pin_dem_a_i),
        .dem_b_i    (pin_dem_b_i),
        .vod_i      (pin_vod_i),
        .side_eq_o  (side_eq),
        .side_dem_o (side_dem),
        .side_vod_o (side_vod),
        .vod_base_o (vod_base),
        .bus_addr_o (bus_addr_o)
    );

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        localparam int unsigned SIDE = (l < HALF) ? 0 : 1;

        cfgsel_lane_mux lane_mux_i (
            .reg_mode_i  (reg_mode_i),
            .lane_reg_i  (lanes_q[l]),
            .strap_eq_i  (side_eq[SIDE]),
            .strap_dem_i (side_dem[SIDE]),
            .strap_vod_i (side_vod[SIDE]),
            .vod_base_i  (vod_base),
            .pin_term_i  (pin_term_i),
            .cfg_o       (lane_cfg[l])
        );

        assign lane_eq_o[l*8 +: 8]   = lane_cfg[l].eq;
        assign lane_dem_o[l*3 +: 3]  = lane_cfg[l].dem;
        assign lane_vod_o[l*3 +: 3]  = lane_cfg[l].vod;
        assign lane_term_dis_o[l]    = lane_cfg[l].term_dis;
    end

    assign mode_o = reg_mode_i ? glob_q.mode : pin_mode_i;
    assign sdth_o = (reg_mode_i && glob_q.ovr_sdth) ? glob_q.sdth : pin_sdth_i;

    AST_ADDR_IDLE_IN_STRAP: assert property (@(posedge clk) disable iff (!por_n)
        !reg_mode_i |-> (bus_addr_o == 4'd0)); // R5

    AST_STRAP_EQ_NIBBLES: assert property (@(posedge clk) disable iff (!por_n)
        !reg_mode_i |-> (lane_eq_o[7:4] == lane_eq_o[3:0])); // R1

    AST_STRAP_VOD_FLOOR: assert property (@(posedge clk) disable iff (!por_n)
        !reg_mode_i |-> (lane_vod_o[2:0] >= 3'd2)); // R3

    AST_REG_EQ_SOURCE: assert property (@(posedge clk) disable iff (!por_n)
        reg_mode_i |-> (lane_eq_o[7:0] == lanes_q[0].eq && mode_o == glob_q.mode)); // R4

    AST_OVR_VOD_SOURCE: assert property (@(posedge clk) disable iff (!por_n)
        (reg_mode_i && lanes_q[0].ovr_vod) |-> (lane_vod_o[2:0] == lanes_q[0].vod)); // R6

endmodule

// File: tb/cfgsel_top_tb_top.sv
module cfgsel_top_tb_top;

    localparam int NL = 4;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          por_n, ext_rst, reg_mode, pin_term, wr_en;
    logic [1:0]    eq_a0, eq_a1, eq_b0, eq_b1, dem_a, dem_b, pmode, pvod, psdth;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [NL*8-1:0] lane_eq;
    logic [NL*3-1:0] lane_dem, lane_vod;
    logic [NL-1:0]   lane_term;
    logic [1:0]      mode_o, sdth_o;
    logic [3:0]      baddr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cfgsel_top #(.NUM_LANES(NL)) dut_i (
        .clk(clk), .por_n(por_n), .ext_rst_i(ext_rst), .reg_mode_i(reg_mode),
        .pin_eq_a0_i(eq_a0), .pin_eq_a1_i(eq_a1), .pin_eq_b0_i(eq_b0), .pin_eq_b1_i(eq_b1),
        .pin_dem_a_i(dem_a), .pin_dem_b_i(dem_b), .pin_mode_i(pmode), .pin_vod_i(pvod),
        .pin_sdth_i(psdth), .pin_term_i(pin_term), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .lane_eq_o(lane_eq), .lane_dem_o(lane_dem), .lane_vod_o(lane_vod),
        .lane_term_dis_o(lane_term), .mode_o(mode_o), .sdth_o(sdth_o), .bus_addr_o(baddr)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eq_of(input int l);  return int'(lane_eq[l*8 +: 8]); endfunction
    function automatic int dem_of(input int l); return int'(lane_dem[l*3 +: 3]); endfunction
    function automatic int vod_of(input int l); return int'(lane_vod[l*3 +: 3]); endfunction

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = AW'(addr);
        wr_data = 8'(data);
        @(negedge clk);
        wr_en   = 1'b0;
        #2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        por_n = 1'b0; ext_rst = 1'b0; reg_mode = 1'b0; pin_term = 1'b0; wr_en = 1'b0;
        eq_a0 = 0; eq_a1 = 0; eq_b0 = 0; eq_b1 = 0; dem_a = 0; dem_b = 0;
        pmode = 0; pvod = 0; psdth = 0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        settle();

        // Reset state in strap mode (R7 defaults visible through straps at zero)
        for (int l = 0; l < NL; l++) begin
            chk("R7 reset eq", eq_of(l), 0);
            chk("R7 reset dem", dem_of(l), 0);
            chk("R7 reset vod", vod_of(l), 2);
            chk("R7 reset term", int'(lane_term[l]), 0);
        end
        chk("R5 reset addr", int'(baddr), 0);

        // R1: all sixteen strap indices, sides opposite
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            eq_a1 = 2'(a >> 2); eq_a0 = 2'(a);
            eq_b1 = 2'((15 - a) >> 2); eq_b0 = 2'(15 - a);
            pmode = 2'(a);
            #2;
            for (int l = 0; l < NL; l++)
                chk("R1 strap eq", eq_of(l), (l < NL / 2 ? a : 15 - a) * 17);
            chk("R5 strap addr zero", int'(baddr), 0);
            chk("R4 strap mode passes", int'(mode_o), a % 4);
        end

        // R2, R3: de-emphasis and amplitude strap combinations
        for (int da = 0; da < 4; da++) begin
            for (int v = 0; v < 4; v++) begin
                @(negedge clk);
                dem_a = 2'(da); dem_b = 2'(3 - da); pvod = 2'(v);
                #2;
                for (int l = 0; l < NL; l++) begin
                    int lvl;
                    lvl = (l < NL / 2) ? da : 3 - da;
                    chk("R2 strap dem", dem_of(l), 2 * lvl);
                    chk("R3 strap vod", vod_of(l), v + 2 + (lvl + 1) / 2);
                end
            end
        end

        // R9: write in strap mode is dropped; R4/R5 immediate switch
        @(negedge clk);
        pvod = 2'd1; pin_term = 1'b1; psdth = 2'd1; dem_a = 2'd0; dem_b = 2'd0;
        eq_a0 = 2'd3; eq_a1 = 2'd0; eq_b0 = 2'd2; eq_b1 = 2'd1;
        wr(16, 8'hAA);
        @(negedge clk);
        reg_mode = 1'b1;
        #2;
        chk("R9 strap write dropped", eq_of(0), 0);
        chk("R4 immediate reg dem", dem_of(0), 0);
        chk("R4 immediate reg mode", int'(mode_o), 0);
        chk("R5 bus address", int'(baddr), 5);

        // R10, R11, R6: per-lane register writes
        for (int l = 0; l < NL; l++) begin
            wr(16 + 4 * l, 8'h3C + 8'h41 * l);
            wr(16 + 4 * l + 1, ((7 - l) << 4) | (l + 1));
        end
        wr(16 + 3, 8'hFF);
        wr(4, 8'hFF);
        for (int l = 0; l < NL; l++) begin
            chk("R10 R11 lane eq", eq_of(l), (8'h3C + 8'h41 * l) & 255);
            chk("R10 R11 lane dem", dem_of(l), l + 1);
            chk("R6 vod from strap", vod_of(l), 3);
            chk("R6 term from strap", int'(lane_term[l]), 1);
        end
        wr(0, 8'h0B);
        chk("R4 reg mode code", int'(mode_o), 3);
        chk("R6 sdth from strap", int'(sdth_o), 1);
        wr(0, 8'h1B);
        chk("R6 sdth override", int'(sdth_o), 2);

        wr(16 + 2, 8'h30);
        chk("R6 lane0 vod override", vod_of(0), 7);
        chk("R6 lane0 term override", int'(lane_term[0]), 0);
        chk("R11 lane1 vod strap", vod_of(1), 3);
        chk("R11 lane1 term strap", int'(lane_term[1]), 1);

        @(negedge clk);
        pvod = 2'd3; pin_term = 1'b0; psdth = 2'd0; dem_a = 2'd3; eq_a1 = 2'd3;
        #2;
        chk("R6 lane0 vod strap ignored", vod_of(0), 7);
        chk("R6 lane1 vod follows strap", vod_of(1), 5);
        chk("R6 lane1 term follows strap", int'(lane_term[1]), 0);
        chk("R6 sdth strap ignored", int'(sdth_o), 2);
        chk("R4 dem strap ignored", dem_of(0), 1);
        chk("R4 eq strap ignored", eq_of(0), 8'h3C);

        // R8: ext reset ignored in register mode
        @(negedge clk);
        ext_rst = 1'b1;
        repeat (3) @(negedge clk);
        ext_rst = 1'b0;
        #2;
        chk("R8 eq kept", eq_of(2), 8'hBE);
        chk("R8 vod kept", vod_of(0), 7);
        chk("R8 mode kept", int'(mode_o), 3);

        // R9 + R7: write in the falling-mode cycle, then back to register mode
        @(negedge clk);
        reg_mode = 1'b0;
        wr_en = 1'b1; wr_addr = AW'(20); wr_data = 8'h5A;
        @(negedge clk);
        wr_en = 1'b0;
        reg_mode = 1'b1;
        #2;
        chk("R9 falling-edge write dropped", eq_of(1), 0);
        chk("R7 eq cleared", eq_of(0), 0);
        chk("R7 override cleared vod", vod_of(0), 5);
        chk("R7 mode cleared", int'(mode_o), 0);
        chk("R7 sdth override cleared", int'(sdth_o), 0);

        // R7: power-on reset in register mode
        wr(16 + 8, 8'h77);
        chk("R10 lane2 eq written", eq_of(2), 8'h77);
        @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        #2;
        chk("R7 por clears", eq_of(2), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule